// File: doc/BRIEF.md
# Streaming Matrix Multiplier

This block multiplies two small signed integer matrices, producing C = A·B. The second operand is presented already transposed, so A is stored as ROWS rows of N elements and the transposed operand as COLS rows of N elements. Every result element is then the dot product of one stored row from each bank. Both operands are loaded through their own write strobe and data port, one element per cycle, and each bank keeps an internal write position.

After both banks hold a complete matrix, a one-cycle start pulse runs the computation. A single multiply-accumulate stage takes one element pair per cycle. For each result it walks through the N element positions. When a dot product is complete, the value appears for one cycle with a valid strobe and its row and column indices. A done pulse marks the end of the run. The matrix dimensions and the operand width are elaboration parameters. The accumulator width is derived from them, so no dot product can overflow.

Top module: `matmul_stream`

## Requirements
- R1: Each bank stores one element per cycle in which its write strobe is high, in row-major order starting at element 0. After the last element (ROWS·N for A, COLS·N for the transposed operand) the write position returns to 0. For A = [[2,5],[7,-1],[0,4]] and B = [[1,1,2],[0,4,0]], the transposed operand is written as 1,0,1,4,2,0.
- R2: The result C[i][j] is the sum over k of A[i][k]·Bt[j][k]. Operands and results are in signed two's complement. For the example operands, C = [[2,22,4],[7,3,14],[0,16,0]].
- R3: The result width is 2·DW + clog2(N) + 1 bits. With full-scale operands (for example, (-128)·(-128) summed twice with DW = 8), the exact value is returned.
- R4: A start pulse is ignored unless both banks have received a complete matrix since reset. An ignored start produces no result and no done pulse.
- R5: Results are emitted in row-major order: row i, then column j. Each result carries its row index on res_row and its column index on res_col.
- R6: Taking the clock edge that samples start as edge 0, result m (counting from 0) is valid after edge (m+1)·N.
- R7: res_valid is high for exactly one cycle per result. With N > 1, consecutive results are separated by idle cycles.
- R8: done is high for one cycle, on the cycle right after the last result C[ROWS-1][COLS-1]. It is pulsed once per run.
- R9: Write strobes that arrive during a run are ignored. They change neither the stored elements nor the write position.
- R10: A start pulse that arrives during a run has no effect on that run.
- R11: The stored operands persist. A new start without any reload computes the same C again.
- R12: After reset, res_valid and done are low and both banks count as not loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| a_we | input | 1 | Write strobe for the A bank |
| a_data | input | DW | Signed element written to A |
| b_we | input | 1 | Write strobe for the transposed-operand bank |
| b_data | input | DW | Signed element written to the transposed operand |
| start | input | 1 | One-cycle pulse that starts a run |
| res_valid | output | 1 | Result strobe |
| res_data | output | 2·DW+clog2(N)+1 | Signed dot product |
| res_row | output | clog2(ROWS) | Row index of the result |
| res_col | output | clog2(COLS) | Column index of the result |
| done | output | 1 | Pulse after the last result of a run |

## Verification
The bench goes after the following corner cases, and each one maps to a distinct failure:

- **Premature start:** it issues a start before either bank is loaded, then again with only A loaded. A design that ignored the loaded flags would emit results built from zeros.
- **Full-scale operands:** one table entry uses operands at both extremes of the range. A narrow or zero-extended accumulator returns a wrong sign or a wrapped value.
- **Strobes during a run:** stray writes and a second start arrive mid-run. A design that let them through would corrupt later results, restart the index walk, or emit a second done.
- **Write position after ignored strobes:** a final reload checks that the position was not advanced by those strobes. Such a design would store the reload shifted by one element.
- **Timing and order:** every result is checked for its exact arrival edge and its indices. This catches an off-by-one in the k counter or a swapped row/column order.

// File: rtl/matmul_pkg.sv
// Shared helpers for the streaming matrix multiplier.
// Assumes all dimension arguments are at least 1.
package matmul_pkg;

    // Width of an index that counts 0..n-1 (at least one bit).
    function automatic int idx_w(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

    // Accumulator width that holds n products of two dw-bit signed values.
    function automatic int acc_w(input int dw, input int n);
        return 2 * dw + ((n > 1) ? $clog2(n) : 0) + 1;
    endfunction

endpackage

// File: rtl/matmul_regbank.sv
// Enable-gated register bank holding one matrix of NROW x LEN signed elements.
// Writes land at an internal position that advances row-major and wraps after
// the last element; 'full' latches once a complete matrix has been written.
// Reads are combinational by (row, element) index. Assumes the caller gates 'we'.
module matmul_regbank
    import matmul_pkg::*;
#(
    parameter int W    = 8,
    parameter int NROW = 3,
    parameter int LEN  = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    we,
    input  logic [W-1:0]            din,
    input  logic [idx_w(NROW)-1:0]  rd_row,
    input  logic [idx_w(LEN)-1:0]   rd_elem,
    output logic [W-1:0]            dout,
    output logic                    full
);
    localparam int DEPTH = NROW * LEN;
    localparam int DAW   = idx_w(DEPTH);
    localparam logic [DAW-1:0] LAST_POS = DAW'(DEPTH - 1);

    logic [DAW-1:0] wpos;
    logic [W-1:0]   cells [DEPTH];
    logic [DAW-1:0] raddr;

    // Advance the write position and latch the loaded flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wpos <= '0;
            full <= 1'b0;
        end else if (we) begin
            if (wpos == LAST_POS) begin
                wpos <= '0;
                full <= 1'b1;
            end else begin
                wpos <= wpos + 1'b1;
            end
        end
    end

    // One register per element, updated only when selected and enabled.
    for (genvar e = 0; e < DEPTH; e++) begin : g_cell
        logic [W-1:0] cell_q;
        always_ff @(posedge clk) begin
            if (!rst_n)
                cell_q <= '0;
            else if (we && (wpos == DAW'(e)))
                cell_q <= din;
        end
        assign cells[e] = cell_q;
    end

    // Row-major read address and output mux.
    always_comb begin
        raddr = DAW'(rd_row) * DAW'(LEN) + DAW'(rd_elem);
        dout  = cells[raddr];
    end

endmodule

// File: rtl/matmul_seq.sv
// Run sequencer: on 'go' walks (i, j, k) with k innermost, one step per cycle,
// then drops 'busy'. Flags mark the last element of a dot product and the
// last pair of the whole run. Assumes 'go' is only raised while idle.
module matmul_seq
    import matmul_pkg::*;
#(
    parameter int ROWS = 3,
    parameter int COLS = 3,
    parameter int N    = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    go,
    output logic                    busy,
    output logic [idx_w(ROWS)-1:0]  row_i,
    output logic [idx_w(COLS)-1:0]  col_j,
    output logic [idx_w(N)-1:0]     elem_k,
    output logic                    last_k,
    output logic                    last_pair
);
    localparam int RW = idx_w(ROWS);
    localparam int CW = idx_w(COLS);
    localparam int KW = idx_w(N);
    localparam logic [RW-1:0] I_END = RW'(ROWS - 1);
    localparam logic [CW-1:0] J_END = CW'(COLS - 1);
    localparam logic [KW-1:0] K_END = KW'(N - 1);

    logic last_j, last_i;

    // End-of-range flags for each counter.
    always_comb begin
        last_k    = (elem_k == K_END);
        last_j    = (col_j == J_END);
        last_i    = (row_i == I_END);
        last_pair = last_k && last_j && last_i;
    end

    // Nested index counters with a run flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy   <= 1'b0;
            row_i  <= '0;
            col_j  <= '0;
            elem_k <= '0;
        end else if (!busy) begin
            busy   <= go;
            row_i  <= '0;
            col_j  <= '0;
            elem_k <= '0;
        end else if (!last_k) begin
            elem_k <= elem_k + 1'b1;
        end else begin
            elem_k <= '0;
            if (!last_j) begin
                col_j <= col_j + 1'b1;
            end else begin
                col_j <= '0;
                if (last_i) begin
                    busy  <= 1'b0;
                    row_i <= '0;
                end else begin
                    row_i <= row_i + 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/matmul_mac.sv
// Signed multiply-accumulate: while 'en', adds a*b to a running sum; on
// 'last' it emits the finished sum with a one-cycle strobe and clears.
// Assumes AW > 2*DW so the sign-extended product fits.
module matmul_mac #(
    parameter int DW = 8,
    parameter int AW = 18
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          last,
    input  logic [DW-1:0] op_a,
    input  logic [DW-1:0] op_b,
    output logic          out_valid,
    output logic [AW-1:0] out_sum
);
    logic signed [2*DW-1:0] prod;
    logic signed [AW-1:0]   prod_ext;
    logic signed [AW-1:0]   acc_q;
    logic signed [AW-1:0]   sum;

    // Signed product, sign-extended and added to the running sum.
    always_comb begin
        prod     = $signed(op_a) * $signed(op_b);
        prod_ext = {{(AW - 2*DW){prod[2*DW-1]}}, prod};
        sum      = acc_q + prod_ext;
    end

    // Accumulate, or emit and clear at the end of a dot product.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q     <= '0;
            out_sum   <= '0;
            out_valid <= 1'b0;
        end else begin
            out_valid <= en && last;
            if (en) begin
                if (last) begin
                    acc_q   <= '0;
                    out_sum <= sum;
                end else begin
                    acc_q <= sum;
                end
            end
        end
    end

endmodule

// File: rtl/matmul_stream.sv
// Streaming matrix multiplier top. Loads A (ROWS x N) and the transposed
// second operand (COLS x N) into register banks, then on 'start' streams
// row pairs through one MAC, emitting each C element with its indices.
// Assumes start is a single-cycle pulse; loads and starts during a run are dropped.
module matmul_stream
    import matmul_pkg::*;
#(
    parameter int ROWS = 3,
    parameter int COLS = 3,
    parameter int N    = 2,
    parameter int DW   = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       a_we,
    input  logic [DW-1:0]              a_data,
    input  logic                       b_we,
    input  logic [DW-1:0]              b_data,
    input  logic                       start,
    output logic                       res_valid,
    output logic [acc_w(DW, N)-1:0]    res_data,
    output logic [idx_w(ROWS)-1:0]     res_row,
    output logic [idx_w(COLS)-1:0]     res_col,
    output logic                       done
);
    localparam int AW = acc_w(DW, N);
    localparam int RW = idx_w(ROWS);
    localparam int CW = idx_w(COLS);
    localparam int KW = idx_w(N);

    logic          busy, ready, go;
    logic          a_full, b_full;
    logic          a_we_g, b_we_g;
    logic [RW-1:0] cur_i;
    logic [CW-1:0] cur_j;
    logic [KW-1:0] cur_k;
    logic          last_k, last_pair;
    logic [DW-1:0] a_elem, b_elem;
    logic          tail_q;

    // Gate writes and start against the run state and the loaded flags.
    always_comb begin
        a_we_g = a_we && !busy;
        b_we_g = b_we && !busy;
        ready  = a_full && b_full;
        go     = start && ready && !busy;
    end

    matmul_regbank #(.W(DW), .NROW(ROWS), .LEN(N)) a_bank_i (
        .clk(clk), .rst_n(rst_n), .we(a_we_g), .din(a_data),
        .rd_row(cur_i), .rd_elem(cur_k), .dout(a_elem), .full(a_full)
    );

    matmul_regbank #(.W(DW), .NROW(COLS), .LEN(N)) b_bank_i (
        .clk(clk), .rst_n(rst_n), .we(b_we_g), .din(b_data),
        .rd_row(cur_j), .rd_elem(cur_k), .dout(b_elem), .full(b_full)
    );

    matmul_seq #(.ROWS(ROWS), .COLS(COLS), .N(N)) seq_i (
        .clk(clk), .rst_n(rst_n), .go(go), .busy(busy),
        .row_i(cur_i), .col_j(cur_j), .elem_k(cur_k),
        .last_k(last_k), .last_pair(last_pair)
    );

    matmul_mac #(.DW(DW), .AW(AW)) mac_i (
        .clk(clk), .rst_n(rst_n), .en(busy), .last(last_k),
        .op_a(a_elem), .op_b(b_elem),
        .out_valid(res_valid), .out_sum(res_data)
    );

    // Capture result indices with the sum; flag and delay the run end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_row <= '0;
            res_col <= '0;
            tail_q  <= 1'b0;
            done    <= 1'b0;
        end else begin
            if (busy && last_k) begin
                res_row <= cur_i;
                res_col <= cur_j;
            end
            tail_q <= busy && last_pair;
            done   <= tail_q;
        end
    end

endmodule

// File: rtl/matmul_stream_chk.sv
// Protocol checker for matmul_stream, attached by bind. Observes the run
// flag, the loaded state and the result interface. Assumes default-style
// small dimensions.
module matmul_stream_chk
    import matmul_pkg::*;
#(
    parameter int ROWS = 3,
    parameter int COLS = 3,
    parameter int N    = 2
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    busy,
    input logic                    ready,
    input logic                    res_valid,
    input logic [idx_w(ROWS)-1:0]  res_row,
    input logic [idx_w(COLS)-1:0]  res_col,
    input logic                    done
);
    localparam logic [idx_w(ROWS)-1:0] ROW_LAST = idx_w(ROWS)'(ROWS - 1);
    localparam logic [idx_w(COLS)-1:0] COL_LAST = idx_w(COLS)'(COLS - 1);
    localparam bit MULTI = (N > 1);

    // R4: no run can begin while the banks are not both loaded.
    p_idle_unloaded_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !ready) |=> !busy);

    // R5: result indices stay inside the matrix.
    p_idx_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> (res_row <= ROW_LAST) && (res_col <= COL_LAST));

    // R6: a result only follows a cycle of an active run.
    p_valid_after_run_r6: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> $past(busy));

    // R7: with more than one element per row, strobes never touch.
    p_valid_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (MULTI && res_valid) |=> !res_valid);

    // R8: done directly follows the final element.
    p_done_last_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(res_valid) && ($past(res_row) == ROW_LAST)
                 && ($past(res_col) == COL_LAST));

    // R8: done is a single-cycle pulse.
    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

endmodule

bind matmul_stream matmul_stream_chk #(.ROWS(ROWS), .COLS(COLS), .N(N)) chk_i (
    .clk(clk), .rst_n(rst_n), .busy(busy), .ready(ready),
    .res_valid(res_valid), .res_row(res_row), .res_col(res_col), .done(done)
);

// File: tb/matmul_stream_tb_top.sv
// Self-checking bench: table-driven load/compute cases, then directed tests.
module matmul_stream_tb_top;
    localparam int ROWS = 3;
    localparam int COLS = 3;
    localparam int N    = 2;
    localparam int DW   = 8;
    localparam int AW   = 2 * DW + $clog2(N) + 1;
    localparam int RW   = $clog2(ROWS);
    localparam int CW   = $clog2(COLS);
    localparam int NA   = ROWS * N;
    localparam int NB   = COLS * N;
    localparam int NC   = ROWS * COLS;
    localparam int NCASE = 2;

    localparam int VEC_A [NCASE][NA] = '{'{2, 5, 7, -1, 0, 4},
                                         '{-128, -128, 127, 127, -1, 0}};
    localparam int VEC_B [NCASE][NB] = '{'{1, 0, 1, 4, 2, 0},
                                         '{-128, -128, 127, -128, 1, 1}};
    localparam int VEC_C [NCASE][NC] = '{'{2, 22, 4, 7, 3, 14, 0, 16, 0},
                                         '{32768, 128, -256, -32512, -127, 254, 128, -127, -1}};

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          a_we = 1'b0, b_we = 1'b0, start = 1'b0;
    logic [DW-1:0] a_data = '0, b_data = '0;
    logic          res_valid, done;
    logic [AW-1:0] res_data;
    logic [RW-1:0] res_row;
    logic [CW-1:0] res_col;

    int checks = 0;
    int fails  = 0;
    int cyc_total = 0;

    always #5 clk = ~clk;

    matmul_stream #(.ROWS(ROWS), .COLS(COLS), .N(N), .DW(DW)) dut_i (
        .clk(clk), .rst_n(rst_n), .a_we(a_we), .a_data(a_data),
        .b_we(b_we), .b_data(b_data), .start(start),
        .res_valid(res_valid), .res_data(res_data),
        .res_row(res_row), .res_col(res_col), .done(done)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Watchdog: a hung run is a failed check, then the summary.
    always @(posedge clk) begin
        cyc_total++;
        if (cyc_total > 150000) begin
            check(1'b0, "watchdog", cyc_total, 150000);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    // R1: load both banks row-major, one element per cycle.
    task automatic load_case(input int c);
        for (int e = 0; e < NA; e++) begin
            @(negedge clk); a_we = 1'b1; a_data = DW'(VEC_A[c][e]);
        end
        @(negedge clk); a_we = 1'b0;
        for (int e = 0; e < NB; e++) begin
            @(negedge clk); b_we = 1'b1; b_data = DW'(VEC_B[c][e]);
        end
        @(negedge clk); b_we = 1'b0;
    endtask

    task automatic pulse_start();
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
    endtask

    // R4: a start that must be ignored yields no strobe at all.
    task automatic expect_quiet(input string req);
        int seen;
        seen = 0;
        pulse_start();
        for (int t = 0; t < 20; t++) begin
            @(negedge clk);
            if (res_valid || done) seen++;
        end
        check(seen == 0, req, seen, 0);
    endtask

    // Run one computation and check every result, its timing and done.
    task automatic run_compute(input int c, input bit glitch);
        int cnt, cyc, prev_v;
        bit fin;
        cnt = 0; cyc = 0; prev_v = 0; fin = 1'b0;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;   // edge 0 has sampled start
        while (!fin && cyc < 200) begin
            if (glitch && cyc == 3) begin
                a_we = 1'b1; a_data = 8'h63; b_we = 1'b1; b_data = 8'h9C; start = 1'b1;
            end else if (glitch && cyc == 4) begin
                a_we = 1'b0; b_we = 1'b0; start = 1'b0;
            end
            @(negedge clk);
            cyc++;
            if (res_valid) begin
                check(cnt < NC, "R10 extra result", cnt, NC - 1);
                if (cnt < NC) begin
                    check(int'($signed(res_data)) == VEC_C[c][cnt], "R2/R3 value",
                          int'($signed(res_data)), VEC_C[c][cnt]);
                    check(int'(res_row) == cnt / COLS, "R5 row", int'(res_row), cnt / COLS);
                    check(int'(res_col) == cnt % COLS, "R5 col", int'(res_col), cnt % COLS);
                    check(cyc == (cnt + 1) * N, "R6 latency", cyc, (cnt + 1) * N);
                end
                check(prev_v == 0, "R7 pulse width", prev_v, 0);
                cnt++;
            end
            prev_v = int'(res_valid);
            if (done) begin
                check(cyc == NC * N + 1, "R8 done timing", cyc, NC * N + 1);
                check(cnt == NC, "R8 result count", cnt, NC);
                fin = 1'b1;
            end
        end
        check(fin, "R8 done seen", int'(fin), 1);
        // R8/R10: no second done after the run.
        cnt = 0;
        for (int t = 0; t < 3 * N; t++) begin
            @(negedge clk);
            if (done || res_valid) cnt++;
        end
        check(cnt == 0, "R10 no restart", cnt, 0);
    endtask

    initial begin
        // R12: reset state.
        repeat (3) @(negedge clk);
        check(res_valid == 1'b0, "R12 valid at reset", int'(res_valid), 0);
        check(done == 1'b0, "R12 done at reset", int'(done), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(res_valid == 1'b0 && done == 1'b0, "R12 idle after reset",
              int'(res_valid) + int'(done), 0);

        // R4: start with nothing loaded, then with A only.
        expect_quiet("R4 start unloaded");
        for (int e = 0; e < NA; e++) begin
            @(negedge clk); a_we = 1'b1; a_data = DW'(VEC_A[0][e]);
        end
        @(negedge clk); a_we = 1'b0;
        expect_quiet("R4 start with A only");

        // Table walk: R1, R2, R3, R5..R10 (case 1 carries mid-run strobes).
        for (int c = 0; c < NCASE; c++) begin
            load_case(c);
            run_compute(c, c == 1);
        end

        // R11: rerun without reloading reproduces the last table case.
        run_compute(1, 1'b0);

        // R9: ignored mid-run writes did not move the write position.
        load_case(0);
        run_compute(0, 1'b0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule